// File: doc/BRIEF.md
# Link Bring-Up Phase Controller

This block steps a serial radio link through its start-up phases. After reset it sits idle; once enabled it waits for layer-1 synchronization, then runs protocol setup, control-and-management setup and option negotiation. It finally settles in either the operating phase or the passive-link phase. Surrounding logic sees the current phase as a 3-bit code in which neighbouring phases differ by one bit. The block also returns a registered copy of the receiver's sync sub-state, which serves as the condition indicator for the synchronization phase. A status bit records the bit-rate negotiation-complete flag so that software can read it back.

Every pin is a plain level-sensitive control or status signal. There is no data stream, so the block has no valid/ready handshake. All pins are synchronous to one recovered-link clock. The parameter `AUTO_RATE` selects whether an external rate-negotiation handshake gates the exit from synchronization. When `AUTO_RATE` is 0, the flag is treated as permanently high.

Top module: `link_bringup_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `phase_o` becomes 000, `sync_code_o` becomes 000 and `rate_stat_o` becomes 0 after that edge.
- R2: In idle (000), `phase_o` moves to synchronization (001) one clock after `enable_i` is sampled high. It stays 000 while `enable_i` is low.
- R3: From synchronization (001), the phase moves to protocol setup (011) one clock after a cycle in which `sync_code_i` equals 110 and the effective rate-done flag is high. In every other case it stays 001.
- R4: With `AUTO_RATE` = 0, `rate_done_i` has no effect. The effective rate-done flag is 1, so `rate_stat_o` reads 1 after the first clock out of reset.
- R5: With sync at 110, protocol setup (011) moves to control setup (010) on `proto_done_i`, and control setup moves to negotiation (110) on `cm_done_i`. Each move appears one clock after the done input is sampled.
- R6: In negotiation (110) with sync at 110 and `nego_done_i` high, the next phase is operation (111) if `active_i` is high and passive link (101) if `active_i` is low.
- R7: In any of phases 011, 010, 110, 111 and 101, a `sync_code_i` other than 110 sends the phase to 001 on the next clock. This rule takes priority over every done input.
- R8: `sync_code_o` equals `sync_code_i` delayed by one clock. The codes are XACQ1 000, XACQ2 001, XSYNC1 011, XSYNC2 010 and HFNSYNC 110.
- R9: With `AUTO_RATE` = 1, `rate_stat_o` equals `rate_done_i` delayed by one clock.
- R10: `phase_o` only ever shows one of the seven phase codes 000, 001, 011, 010, 110, 111, 101.
- R11: A phase holds its code while neither its advance condition nor loss of sync is present. Operation and passive link are held indefinitely while sync is 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered-link clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Starts bring-up from idle |
| sync_code_i | input | 3 | Receiver sync sub-state code |
| rate_done_i | input | 1 | Bit-rate negotiation complete |
| proto_done_i | input | 1 | Protocol setup finished (one cycle) |
| cm_done_i | input | 1 | Control/management setup finished (one cycle) |
| nego_done_i | input | 1 | Interface/option negotiation finished |
| active_i | input | 1 | Selects operation (1) or passive link (0) |
| phase_o | output | 3 | Current phase code |
| sync_code_o | output | 3 | Registered sync sub-state mirror |
| rate_stat_o | output | 1 | Captured effective rate-done status bit |

## Verification
The assertions assume that `sync_code_i` and the done and mode inputs are stable around the rising edge, and that `rst` is synchronous. They do not assume that the sync code is one of the five legal values, because any code other than 110 counts as loss of sync. The bench changes inputs only on falling edges. It sweeps all 512 combinations of the nine inputs in a scrambled order, and it holds the sync code at 110 for most cycles so that the late phases are reached and held. At fixed intervals it injects each of the other sync codes, so that every phase sees loss of sync.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int unsigned PHASE_W = 3;
  localparam int unsigned SYNC_W  = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE    = 3'b000,
    PH_L1      = 3'b001,
    PH_PROT    = 3'b011,
    PH_CM      = 3'b010,
    PH_NEG     = 3'b110,
    PH_RUN     = 3'b111,
    PH_PASSIVE = 3'b101
  } phase_e;

  // receiver sub-state codes
  localparam logic [SYNC_W-1:0] SY_ACQ1   = 3'b000;
  localparam logic [SYNC_W-1:0] SY_ACQ2   = 3'b001;
  localparam logic [SYNC_W-1:0] SY_SYNC1  = 3'b011;
  localparam logic [SYNC_W-1:0] SY_SYNC2  = 3'b010;
  localparam logic [SYNC_W-1:0] SY_LOCKED = 3'b110;
endpackage

// File: rtl/lbc_sync_track.sv
module lbc_sync_track
  import lbc_pkg::*;
#(
  parameter int unsigned W = SYNC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  output logic         locked_o,
  output logic [W-1:0] sync_o
);
  // Lock is judged on the live code so that the phase machine reacts
  // in the same cycle the receiver reports it.
  assign locked_o = (sync_i == W'(SY_LOCKED));

  always_ff @(posedge clk) begin
    if (rst) sync_o <= '0;
    else     sync_o <= sync_i;
  end

  p_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_o == $past(sync_i)));
endmodule

// File: rtl/lbc_rate_gate.sv
module lbc_rate_gate #(
  parameter bit AUTO_RATE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_i,
  output logic rate_eff_o,
  output logic stat_o
);
  generate
    if (AUTO_RATE) begin : g_handshake
      assign rate_eff_o = rate_i;
    end else begin : g_tied
      assign rate_eff_o = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stat_o <= 1'b0;
    else     stat_o <= rate_eff_o;
  end

  generate
    if (!AUTO_RATE) begin : g_tied_chk
      p_tied_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_o);
    end
  endgenerate
endmodule

// File: rtl/lbc_phase_fsm.sv
module lbc_phase_fsm
  import lbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   enable_i,
  input  logic   locked_i,
  input  logic   rate_eff_i,
  input  logic   proto_done_i,
  input  logic   cm_done_i,
  input  logic   nego_done_i,
  input  logic   active_i,
  output phase_e phase_o
);
  phase_e nxt;

  always_comb begin
    nxt = phase_o;
    unique case (phase_o)
      PH_IDLE: if (enable_i) nxt = PH_L1;
      PH_L1:   if (locked_i && rate_eff_i) nxt = PH_PROT;
      PH_PROT: if (!locked_i) nxt = PH_L1;
               else if (proto_done_i) nxt = PH_CM;
      PH_CM:   if (!locked_i) nxt = PH_L1;
               else if (cm_done_i) nxt = PH_NEG;
      PH_NEG:  if (!locked_i) nxt = PH_L1;
               else if (nego_done_i) nxt = active_i ? PH_RUN : PH_PASSIVE;
      PH_RUN, PH_PASSIVE: if (!locked_i) nxt = PH_L1;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_o <= PH_IDLE;
    else     phase_o <= nxt;
  end

  p_legal_r10: assert property (@(posedge clk) disable iff (rst)
    phase_o inside {PH_IDLE, PH_L1, PH_PROT, PH_CM, PH_NEG, PH_RUN, PH_PASSIVE});

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_IDLE && !enable_i) |=> phase_o == PH_IDLE);

  p_idle_go_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_IDLE && enable_i) |=> phase_o == PH_L1);

  p_l1_exits_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_L1) |=> (phase_o == PH_L1 || phase_o == PH_PROT));

  p_l1_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_L1 && !(locked_i && rate_eff_i)) |=> phase_o == PH_L1);

  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_o != PH_IDLE && phase_o != PH_L1 && !locked_i) |=> phase_o == PH_L1);

  p_split_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_NEG && locked_i && nego_done_i) |=>
      (phase_o == PH_RUN || phase_o == PH_PASSIVE));

  p_final_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ((phase_o == PH_RUN || phase_o == PH_PASSIVE) && locked_i) |=> $stable(phase_o));
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
  import lbc_pkg::*;
#(
  parameter bit AUTO_RATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [SYNC_W-1:0] sync_code_i,
  input  logic              rate_done_i,
  input  logic              proto_done_i,
  input  logic              cm_done_i,
  input  logic              nego_done_i,
  input  logic              active_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [SYNC_W-1:0] sync_code_o,
  output logic              rate_stat_o
);
  logic   locked;
  logic   rate_eff;
  phase_e phase;

  lbc_sync_track #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .sync_i(sync_code_i),
    .locked_o(locked), .sync_o(sync_code_o)
  );

  lbc_rate_gate #(.AUTO_RATE(AUTO_RATE)) u_rate (
    .clk(clk), .rst(rst), .rate_i(rate_done_i),
    .rate_eff_o(rate_eff), .stat_o(rate_stat_o)
  );

  lbc_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .enable_i(enable_i), .locked_i(locked),
    .rate_eff_i(rate_eff), .proto_done_i(proto_done_i),
    .cm_done_i(cm_done_i), .nego_done_i(nego_done_i),
    .active_i(active_i), .phase_o(phase)
  );

  assign phase_o = phase;
endmodule

// File: tb/test_link_bringup_ctrl.sv
`timescale 1ns/1ps
module test_link_bringup_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, rate = 1'b0, pd = 1'b0, cd = 1'b0, nd = 1'b0, act = 1'b0;
  logic [2:0] sy = 3'b000;
  logic [2:0] ph_a, sy_a, ph_b, sy_b;
  logic st_a, st_b;
  int n_tests = 0, n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  link_bringup_ctrl #(.AUTO_RATE(1'b1)) i_link_bringup_ctrl (
    .clk(clk), .rst(rst), .enable_i(en), .sync_code_i(sy), .rate_done_i(rate),
    .proto_done_i(pd), .cm_done_i(cd), .nego_done_i(nd), .active_i(act),
    .phase_o(ph_a), .sync_code_o(sy_a), .rate_stat_o(st_a));

  link_bringup_ctrl #(.AUTO_RATE(1'b0)) i_link_bringup_ctrl_tied (
    .clk(clk), .rst(rst), .enable_i(en), .sync_code_i(sy), .rate_done_i(rate),
    .proto_done_i(pd), .cm_done_i(cd), .nego_done_i(nd), .active_i(act),
    .phase_o(ph_b), .sync_code_o(sy_b), .rate_stat_o(st_b));

  function automatic logic [2:0] model(input logic [2:0] s, input logic e,
      input logic [2:0] y, input logic r, input logic p, input logic c,
      input logic n, input logic a);
    logic lk;
    lk = (y == 3'b110);
    case (s)
      3'b000: return e ? 3'b001 : 3'b000;
      3'b001: return (lk && r) ? 3'b011 : 3'b001;
      3'b011: return !lk ? 3'b001 : (p ? 3'b010 : 3'b011);
      3'b010: return !lk ? 3'b001 : (c ? 3'b110 : 3'b010);
      3'b110: return !lk ? 3'b001 : (n ? (a ? 3'b111 : 3'b101) : 3'b110);
      default: return !lk ? 3'b001 : s;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic [2:0] y);
    if (s != 3'b000 && s != 3'b001 && y != 3'b110) return "R7";
    case (s)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b011, 3'b010: return "R5";
      3'b110: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  logic [2:0] m_a = 3'b000, m_b = 3'b000;

  // drive at a falling edge, check shortly after the next rising edge
  task automatic step(input logic e, input logic [2:0] y, input logic r,
      input logic p, input logic c, input logic n, input logic a);
    logic [2:0] ea, eb;
    string ta, tb;
    en = e; sy = y; rate = r; pd = p; cd = c; nd = n; act = a;
    ea = model(m_a, e, y, r, p, c, n, a);
    eb = model(m_b, e, y, 1'b1, p, c, n, a);
    ta = tag_of(m_a, y);
    tb = (m_b == 3'b001) ? "R4" : tag_of(m_b, y);
    @(posedge clk); #1;
    check(ta, ph_a, ea);
    check(tb, ph_b, eb);
    check("R8", sy_a, y);
    check("R9", {2'b00, st_a}, {2'b00, r});
    check("R4", {2'b00, st_b}, 3'b001);
    check("R10", {2'b00, ph_a inside {3'b000,3'b001,3'b011,3'b010,3'b110,3'b111,3'b101}}, 3'b001);
    m_a = ea; m_b = eb;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R1", ph_a, 3'b000); check("R1", sy_a, 3'b000);
    check("R1", {2'b00, st_a}, 3'b000); check("R1", ph_b, 3'b000);
    check("R1", {2'b00, st_b}, 3'b000);
    m_a = 3'b000; m_b = 3'b000;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    // R2: idle holds without enable
    for (int i = 0; i < 3; i++) step(1'b0, 3'b110, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 3'b000, 1'b0, 0, 0, 0, 0);
    // R3: lock without rate, rate without lock, then both
    step(1'b0, 3'b110, 1'b0, 0, 0, 0, 0);
    step(1'b0, 3'b010, 1'b1, 0, 0, 0, 0);
    step(1'b0, 3'b110, 1'b1, 0, 0, 0, 0);
    // R5 and R6: walk to passive link
    step(1'b0, 3'b110, 1'b0, 1, 0, 0, 0);
    step(1'b0, 3'b110, 1'b0, 0, 1, 0, 0);
    step(1'b0, 3'b110, 1'b0, 0, 0, 1, 0);
    step(1'b0, 3'b110, 1'b0, 0, 0, 1, 1);
    // R7: loss of sync beats done inputs
    step(1'b0, 3'b011, 1'b1, 1, 1, 1, 1);
    // near-exhaustive scrambled sweep over all 9-bit input combos
    for (int n = 0; n < 6000; n++) begin
      int k;
      logic [2:0] ys;
      k = (n * 173 + n / 512) % 512;
      ys = (n % 7 == 3) ? 3'(k) : 3'b110;
      step(k[3], ys, k[4], k[5], k[6], k[7], k[8]);
      if (n % 1500 == 1499) do_reset();
    end
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule